// File: doc/BRIEF.md
# Status LED Blink Code Generator

This block drives one status LED so that an operator can read the state of a board power sequencer from its blink code. The sequencer supplies a 3-bit state code. Each state that reports a fault or a readiness level has its own pattern of 8 equal time slots. A pattern always starts with its lit slots, and the rest of the cycle is dark. Because every pattern lasts the same time, the states differ only in how many of the 8 slots are lit. An idle-state fault is shown as a faster, even on/off square wave, so it stands out from the slow codes.

When the FPGA reports that its configuration is done, the patterns stop and the LED follows a user LED signal that comes from the FPGA. The LED output comes straight from a flip-flop. Whenever the state code changes, the slot counter and the fast divider restart, so a new code always begins at its first lit slot. Two divider lengths are parameters: `SLOT_CYCLES` is the clock cycles per slot, and `FAST_CYCLES` is the clock cycles per half period of the fast blink. At 100 MHz the defaults give about 1.4 s per pattern and about 5.8 Hz for the fast blink.

Top module: `status_led_blinker`

## Requirements
- R1: Code 0 (idle fault) gives a square wave that is lit for `FAST_CYCLES` cycles and dark for `FAST_CYCLES` cycles, starting lit.
- R2: Each slot lasts exactly `SLOT_CYCLES` clock cycles, and 8 slots form one pattern that repeats without a gap.
- R3: Code 1 lights slots 0 to 4 and leaves slots 5 to 7 dark.
- R4: Code 2 lights slots 0 to 3 and leaves slots 4 to 7 dark.
- R5: Code 3 (power ready, FPGA not configured) lights slots 0 to 2 and leaves slots 3 to 7 dark.
- R6: Codes 4 and 5 are spare patterns that light 2 slots and 1 slot respectively.
- R7: Codes 6 and 7 keep the LED dark.
- R8: While `fpga_done` is high, `led` takes the value `user_led` had on the previous clock edge, whatever the code.
- R9: A change of `state_code` restarts the pattern. The edge that sees the new code clears the slot and divider counters, and the next edge shows slot 0 (or the lit fast phase) of the new code. If the same code is applied again, the pattern does not restart.
- R10: While reset is held, and on the first edge after it, `led` is low. Reset loads code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| state_code | input | 3 | Power state code from the sequencer |
| fpga_done | input | 1 | FPGA configuration finished |
| user_led | input | 1 | LED level requested by the FPGA |
| led | output | 1 | Registered LED drive, high means lit |

## Verification
The assertions assume that `state_code`, `fpga_done` and `user_led` are synchronous to `clk` and change only between edges. They also assume that `SLOT_CYCLES` and `FAST_CYCLES` are at least 2, so that each divider wraps only after it reaches its terminal count. The bench drives every input at the falling edge. It holds each random setting for a random number of cycles, from one cycle up to several full patterns. The run lengths include single-cycle code changes that land in the middle of a slot, and repeats of the same code, so the restart rule is exercised.

// File: rtl/status_led_blinker.sv
module status_led_blinker #(
  parameter int unsigned SLOT_CYCLES = 17_500_000,
  parameter int unsigned FAST_CYCLES = 8_620_690
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] state_code,
  input  logic       fpga_done,
  input  logic       user_led,
  output logic       led
);
  localparam int unsigned SW = $clog2(SLOT_CYCLES + 1);
  localparam int unsigned FW = $clog2(FAST_CYCLES + 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_CYCLES - 1);
  localparam logic [FW-1:0] FAST_LAST = FW'(FAST_CYCLES - 1);

  logic [2:0]    st_q;
  logic [2:0]    slot;
  logic [SW-1:0] cnt;
  logic [FW-1:0] fcnt;
  logic          fph;
  logic [3:0]    on_slots;
  logic          restart, slot_tick, fast_tick, pat;

  assign restart   = state_code != st_q;
  assign slot_tick = cnt == SLOT_LAST;
  assign fast_tick = fcnt == FAST_LAST;

  always_comb begin
    case (st_q)
      3'd1:    on_slots = 4'd5;
      3'd2:    on_slots = 4'd4;
      3'd3:    on_slots = 4'd3;
      3'd4:    on_slots = 4'd2;
      3'd5:    on_slots = 4'd1;
      default: on_slots = 4'd0;
    endcase
  end

  assign pat = (st_q == 3'd0) ? fph : ({1'b0, slot} < on_slots);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= 3'd7;
      cnt  <= '0;
      slot <= '0;
      fcnt <= '0;
      fph  <= 1'b1;
      led  <= 1'b0;
    end else begin
      led <= fpga_done ? user_led : pat;
      if (restart) begin
        st_q <= state_code;
        cnt  <= '0;
        slot <= '0;
        fcnt <= '0;
        fph  <= 1'b1;
      end else begin
        cnt  <= slot_tick ? '0 : cnt + 1'b1;
        slot <= slot + {2'b00, slot_tick};
        fcnt <= fast_tick ? '0 : fcnt + 1'b1;
        fph  <= fph ^ fast_tick;
      end
    end
  end

  a_r8_user_follow: assert property (@(posedge clk) disable iff (!rst_n)
    fpga_done |=> led == $past(user_led));

  a_r7_spare_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (!fpga_done && st_q[2:1] == 2'b11) |=> !led);

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (slot == 3'd0 && cnt == '0 && fcnt == '0 && fph));

  a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !slot_tick) |=> $stable(slot));

  a_r1_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !fast_tick) |=> $stable(fph));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SLOT_LAST);
endmodule

// File: tb/status_led_blinker_test.sv
module status_led_blinker_test;
  localparam int unsigned S = 5;
  localparam int unsigned F = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] state_code = 3'd7;
  logic       fpga_done = 1'b0;
  logic       user_led = 1'b0;
  logic       led;

  int checks = 0;
  int fails = 0;
  logic [2:0] mcode = 3'd7;
  int mk = 0;

  always #5 clk = ~clk;

  status_led_blinker #(.SLOT_CYCLES(S), .FAST_CYCLES(F)) uut (
    .clk(clk), .rst_n(rst_n), .state_code(state_code),
    .fpga_done(fpga_done), .user_led(user_led), .led(led));

  function automatic logic pattern_of(logic [2:0] code, int k);
    int lit;
    if (code == 3'd0) return ((k / F) % 2) == 0;
    case (code)
      3'd1: lit = 5;
      3'd2: lit = 4;
      3'd3: lit = 3;
      3'd4: lit = 2;
      3'd5: lit = 1;
      default: lit = 0;
    endcase
    return ((k / S) % 8) < lit;
  endfunction

  function automatic string tag_of(logic [2:0] code, logic done);
    if (done) return "R8";
    case (code)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: led=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    logic exp;
    string t;
    exp = fpga_done ? user_led : pattern_of(mcode, mk);
    t = (tag.len() != 0) ? tag : tag_of(mcode, fpga_done);
    if (state_code != mcode) begin
      mcode = state_code;
      mk = 0;
    end else mk++;
    @(posedge clk);
    @(negedge clk);
    check(led, exp, t);
  endtask

  task automatic run(logic [2:0] code, logic done, logic usr, int n, string tag);
    state_code = code;
    fpga_done = done;
    user_led = usr;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: led=%0d expected=finish", led);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(led, 1'b0, "R10");
    rst_n = 1'b1;
    step("R10");
    // every code with a full pattern and a half
    for (int c = 0; c < 8; c++) run(3'(c), 1'b0, 1'b0, 12 * S + 1, "");
    // R2: slot length over two full patterns of code 1
    run(3'd2, 1'b0, 1'b0, 1, "R2");
    run(3'd1, 1'b0, 1'b0, 16 * S + 2, "R2");
    // R9: change mid-slot, then a repeat of the same code
    run(3'd3, 1'b0, 1'b0, S + 2, "R9");
    run(3'd4, 1'b0, 1'b0, 1, "R9");
    run(3'd3, 1'b0, 1'b0, 2, "R9");
    run(3'd3, 1'b0, 1'b0, 4 * S, "R9");
    run(3'd0, 1'b0, 1'b0, 2, "R9");
    run(3'd0, 1'b0, 1'b0, 3 * F, "R9");
    // R8: user control, and hand-back to the pattern
    run(3'd2, 1'b1, 1'b1, 4, "R8");
    run(3'd2, 1'b1, 1'b0, 3, "R8");
    run(3'd6, 1'b1, 1'b1, 3, "R8");
    run(3'd2, 1'b0, 1'b1, 3 * S, "");
    // R10: reset mid-pattern
    run(3'd1, 1'b0, 1'b0, 3, "");
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(led, 1'b0, "R10");
    rst_n = 1'b1;
    mcode = 3'd7;
    mk = 0;
    state_code = 3'd7;
    step("R10");
    // constrained random stimulus
    void'($urandom(32'h5eed_1ed5));
    for (int r = 0; r < 300; r++) begin
      logic [2:0] c;
      logic d, u;
      int n;
      c = 3'($urandom_range(0, 7));
      d = ($urandom_range(0, 3) == 0);
      u = 1'($urandom());
      n = ($urandom_range(0, 3) == 0) ? 1 : $urandom_range(2, 10 * S);
      run(c, d, u, n, "");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule